// File: doc/BRIEF.md
# Reference-Counted Power-Domain Wake Sequencer

This block sits between software-facing clients and a set of power domains. A client sends one command at a time: either a request to keep some domains powered, or a release of such a request, together with a bit mask naming the domains. The block keeps a saturating reference count for every domain. A domain's hardware is touched only when its count moves between zero and one. On that edge the block emits a masked control word on a simple one-cycle register-write port.

The block handles one command in two passes over the domains, both in ascending index order. The first pass updates the counts and issues every control write the command needs. The second pass then watches the acknowledge input of each domain whose state changed, and gives each one its own cycle-count timeout. A timeout does not stop the command; it only raises the error flag, which is returned together with the done pulse. The mask of awake domains is updated at the same moment.

Top module: `wake_refcount_seq`

## Requirements
- R1: A wake write carries data 32'h0001_0001 (write-enable bit 16 and value bit 0). A sleep write carries 32'h0001_0000. `wr_dom` gives the domain index, and `wr_en` is high for exactly one cycle per write.
- R2: A get increments the count of each selected domain. A write is issued only for a domain whose count was zero before the get.
- R3: A put decrements the count of each selected domain. A sleep write is issued only for a domain whose count becomes zero.
- R4: Writes for one command come out in ascending domain order, one write per cycle slot. Every write comes before any acknowledge is evaluated.
- R5: A selected domain whose `present` bit is low is skipped: no write, and its count does not change.
- R6: In the acknowledge pass, a woken domain is settled when `ack` reads 1 and a sleeping domain when it reads 0. The pass spends one cycle on each domain that is settled or unchanged. The done pulse appears NDOM + (sum of per-domain cycles) cycles after the accepting edge.
- R7: A domain that does not settle is given up after TIMEOUT_CYC cycles. The remaining domains are still processed, and `err` is high with `done`.
- R8: At `done`, `awake` gains every domain woken by a get and loses every domain put to sleep by a put. It does not change at any other time.
- R9: A put on a domain whose count is zero sets `err`, leaves the count at zero and issues no write.
- R10: A get on a domain whose count is at its maximum (2^CNT_W-1) sets `err`, leaves the count unchanged and issues no write.
- R11: A command is accepted only while `busy` is low, and `cmd_valid` while busy has no effect. `done` is a one-cycle pulse, and `busy` falls in the same cycle.
- R12: After reset, `busy`, `done`, `err`, `wr_en` and `awake` are all zero and all counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_put | input | 1 | 0 = get (wake), 1 = put (release) |
| cmd_mask | input | NDOM | Domains the command applies to |
| present | input | NDOM | Domains that have a control register |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error result of the last command |
| awake | output | NDOM | Domains currently awake |
| wr_en | output | 1 | Control write strobe |
| wr_dom | output | IDX_W | Target domain of the write |
| wr_data | output | 32 | Masked control word |
| ack | input | NDOM | Per-domain acknowledge bit |

## Verification
The hardest case to reach from the ports is a timeout on one domain inside a command that also changes other domains. The bench's acknowledge model has a per-domain stuck switch, so one domain can be held while its neighbours follow their writes normally. Done latency, the error flag and the awake mask are then checked against a reference count model. A sweep of all mask pairs pushes the 2-bit counts into both underflow and saturation. A second command is also pulsed mid-flight to show that it is refused.

// File: rtl/wake_refcount_seq.sv
module wake_refcount_seq #(
  parameter int NDOM        = 16,
  parameter int CNT_W       = 8,
  parameter int TIMEOUT_CYC = 2500000,
  localparam int IDX_W      = (NDOM > 1) ? $clog2(NDOM) : 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_put,
  input  logic [NDOM-1:0]  cmd_mask,
  input  logic [NDOM-1:0]  present,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [NDOM-1:0]  awake,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_dom,
  output logic [31:0]      wr_data,
  input  logic [NDOM-1:0]  ack
);
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_WR, S_WAIT} st_t;

  st_t              st;
  logic [IDX_W-1:0] idx;
  logic             put_q;
  logic [NDOM-1:0]  sel_q, chg;
  logic [TMR_W-1:0] tmr;
  logic [CNT_W-1:0] cnt [NDOM];

  wire last   = (idx == IDX_W'(NDOM - 1));
  wire zero   = (cnt[idx] == '0);
  wire full   = (&cnt[idx]);
  wire ack_ok = (ack[idx] == !put_q);
  wire expire = (tmr == TMR_W'(TIMEOUT_CYC - 1));

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx     <= '0;
      put_q   <= 1'b0;
      sel_q   <= '0;
      chg     <= '0;
      tmr     <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
      awake   <= '0;
      wr_en   <= 1'b0;
      wr_dom  <= '0;
      wr_data <= '0;
      for (int i = 0; i < NDOM; i++) cnt[i] <= '0;
    end else begin
      done  <= 1'b0;
      wr_en <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          st    <= S_WR;
          idx   <= '0;
          put_q <= cmd_put;
          sel_q <= cmd_mask & present;
          chg   <= '0;
          err   <= 1'b0;
        end
        S_WR: begin
          if (sel_q[idx]) begin
            if (!put_q) begin
              if (full) err <= 1'b1;
              else begin
                cnt[idx] <= cnt[idx] + CNT_ONE;
                if (zero) begin
                  wr_en    <= 1'b1;
                  wr_dom   <= idx;
                  wr_data  <= 32'h0001_0001;
                  chg[idx] <= 1'b1;
                end
              end
            end else begin
              if (zero) err <= 1'b1;
              else begin
                cnt[idx] <= cnt[idx] - CNT_ONE;
                if (cnt[idx] == CNT_ONE) begin
                  wr_en    <= 1'b1;
                  wr_dom   <= idx;
                  wr_data  <= 32'h0001_0000;
                  chg[idx] <= 1'b1;
                end
              end
            end
          end
          if (last) begin
            st  <= S_WAIT;
            idx <= '0;
            tmr <= '0;
          end else idx <= idx + 1'b1;
        end
        S_WAIT: begin
          if (!chg[idx] || ack_ok || expire) begin
            if (chg[idx] && !ack_ok) err <= 1'b1;
            tmr <= '0;
            if (last) begin
              st    <= S_IDLE;
              done  <= 1'b1;
              awake <= put_q ? (awake & ~chg) : (awake | chg);
            end else idx <= idx + 1'b1;
          end else tmr <= tmr + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_WORD_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data[31:1] == 31'h0000_8000)); // R1
  AST_WAKE_FROM_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[0]) |-> !awake[wr_dom]); // R2
  AST_SLEEP_FROM_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[0]) |-> awake[wr_dom]); // R3
  AST_AWAKE_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(awake)); // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R11
  AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
endmodule

// File: tb/sim_wake_refcount_seq.sv
module sim_wake_refcount_seq;
  localparam int ND = 4, CW = 2, TO = 8;
  localparam logic [ND-1:0] PRES = 4'b1011;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_put = 1'b0;
  logic [ND-1:0] cmd_mask = '0;
  logic busy, done, err, wr_en;
  logic [ND-1:0] awake;
  logic [ND-1:0] ack = '0;
  logic [ND-1:0] stuck = '0;
  logic [1:0] wr_dom;
  logic [31:0] wr_data;

  int checks = 0, fails = 0;
  int log_n = 0;
  int log_dom [4096];
  logic [31:0] log_dat [4096];
  int mcnt [ND];
  logic [ND-1:0] mack = '0, mawake = '0;

  always #10 clk = ~clk;

  wake_refcount_seq #(.NDOM(ND), .CNT_W(CW), .TIMEOUT_CYC(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_put(cmd_put),
    .cmd_mask(cmd_mask), .present(PRES), .busy(busy), .done(done), .err(err),
    .awake(awake), .wr_en(wr_en), .wr_dom(wr_dom), .wr_data(wr_data), .ack(ack));

  always @(posedge clk) begin
    if (wr_en) begin
      if (!stuck[wr_dom]) ack[wr_dom] <= wr_data[0];
      if (log_n < 4096) begin
        log_dom[log_n] <= int'(wr_dom);
        log_dat[log_n] <= wr_data;
      end
      log_n <= log_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input bit put, input logic [ND-1:0] m, input bit intrude);
    int ew_dom [ND];
    logic [31:0] ew_dat [ND];
    int ew_n = 0, cyc = ND, n = 0, base;
    bit eerr = 0;
    logic [ND-1:0] ch = '0;
    for (int i = 0; i < ND; i++) begin
      if (m[i] && PRES[i]) begin
        if (!put) begin
          if (mcnt[i] == (1 << CW) - 1) eerr = 1;
          else begin
            if (mcnt[i] == 0) begin ch[i] = 1; ew_dom[ew_n] = i; ew_dat[ew_n] = 32'h0001_0001; ew_n++; end
            mcnt[i]++;
          end
        end else begin
          if (mcnt[i] == 0) eerr = 1;
          else begin
            mcnt[i]--;
            if (mcnt[i] == 0) begin ch[i] = 1; ew_dom[ew_n] = i; ew_dat[ew_n] = 32'h0001_0000; ew_n++; end
          end
        end
      end
    end
    for (int i = 0; i < ND; i++) begin
      if (ch[i] && stuck[i] && mack[i] != !put) begin eerr = 1; cyc += TO; end
      else cyc += 1;
      if (ch[i] && !stuck[i]) mack[i] = !put;
    end
    mawake = put ? (mawake & ~ch) : (mawake | ch);
    @(negedge clk);
    base = log_n;
    cmd_valid = 1'b1; cmd_put = put; cmd_mask = m;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (1) begin
      @(negedge clk);
      n++;
      if (intrude && n == 2) begin cmd_valid = 1'b1; cmd_put = 1'b0; cmd_mask = '1; end
      if (intrude && n == 3) cmd_valid = 1'b0;
      if (done || n > 200) break;
    end
    chk(n == cyc, "R6 done latency", n, cyc);
    chk(err == eerr, put ? "R9 R7 put err" : "R10 R7 get err", err, eerr);
    chk(awake == mawake, "R8 awake mask", awake, mawake);
    chk(!busy, "R11 busy low at done", busy, 0);
    chk(log_n - base == ew_n, "R2 R3 R5 write count", log_n - base, ew_n);
    for (int k = 0; k < ew_n && k < log_n - base; k++) begin
      chk(log_dom[base + k] == ew_dom[k], "R4 write order", log_dom[base + k], ew_dom[k]);
      chk(log_dat[base + k] == ew_dat[k], "R1 write word", log_dat[base + k], ew_dat[k]);
    end
    if (intrude) begin
      repeat (3) @(negedge clk);
      chk(!busy && log_n == base + ew_n, "R11 refused while busy", log_n - base, ew_n);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < ND; i++) mcnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err && !wr_en && awake == 0, "R12 reset state",
        {busy, done, err, wr_en, awake}, 0);
    for (int m = 0; m < 16; m++) run(1'b0, ND'(m), 1'b0);
    for (int m = 0; m < 16; m++) run(1'b1, ND'(m), 1'b0);
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        run(1'b0, ND'(a), (a == 5 && b == 3));
        run(1'b1, ND'(b), 1'b0);
      end
    stuck = 4'b0010;
    run(1'b0, 4'b1011, 1'b0);
    run(1'b1, 4'b0011, 1'b0);
    run(1'b0, 4'b0010, 1'b0);
    stuck = 4'b0000;
    run(1'b1, 4'b0010, 1'b0);
    run(1'b1, 4'b1111, 1'b0);
    run(1'b0, 4'b0100, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule